// File: doc/BRIEF.md
# Inter-Processor Doorbell and Acknowledge Controller

This block holds the doorbell and acknowledge flags for a group of processors that pass messages through shared mailbox memory. The memory that holds a message sits in the receiving processor's subsystem. A sender first places its payload in the receiver's mailbox, then rings the receiver. The receiver sees one combined request interrupt. It clears the flag for that sender, reads the message, and then raises an acknowledge back to the sender. The sender sees one combined acknowledge interrupt and clears it.

Each processor owns a private register port with four registers. Two of them are trigger registers that a processor writes in its own space to set a flag in another processor's status. The other two are status registers that the owning processor clears by writing ones. Processor indices can be sparse, so the number of processors `NPROC` must be the highest index in use plus one. The default of 7 covers a main core at index 0 and a security core at index 6.

Top module: `mbox_doorbell`

## Requirements
- R1: A write by processor S to its own register 0 (ring trigger) with bit R set makes bit S of processor R's pending register (register 1) read 1 from the next cycle.
- R2: Each processor's request interrupt `irq_req[p]` is registered and is high exactly when any bit of its pending register is 1. It rises in the same cycle that the pending bit becomes visible.
- R3: A write by processor R to its own register 1 clears every pending bit that is written as 1 (write-one-to-clear), starting in the next cycle.
- R4: A write by processor R to its own register 2 (acknowledge trigger) with bit S set makes bit R of processor S's done register (register 3) read 1 from the next cycle.
- R5: Each processor's acknowledge interrupt `irq_ack[p]` is registered and is high exactly when any bit of its done register is 1.
- R6: A write by processor S to its own register 3 clears every done bit that is written as 1, starting in the next cycle.
- R7: Bits written as 0 to any register change nothing. Registers 0 and 2 always read as 0. A status bit changes only through a set or a clear aimed at it.
- R8: When a set and a clear reach the same status bit in the same cycle, the bit ends up at 1.
- R9: After reset, every status bit and every interrupt is 0.
- R10: With the default of 7 processors, a full ring, clear, acknowledge and clear exchange between index 0 and index 6 completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | NPROC | Per-processor write strobe |
| bus_sel | input | 2*NPROC | Per-processor register select, 2 bits per port (0 ring, 1 pending, 2 acknowledge, 3 done) |
| bus_wdata | input | NPROC*NPROC | Per-processor write data, NPROC bits per port |
| bus_rdata | output | NPROC*NPROC | Per-processor read data for the selected register, combinational from state |
| irq_req | output | NPROC | Combined request interrupt per processor |
| irq_ack | output | NPROC | Combined acknowledge interrupt per processor |

## Verification
A directed exchange between indices 0 and 6 walks through the message protocol in order. Each step shows one path at a time: the ring path, the pending clear, the acknowledge path and the done clear. Further directed cases apply a ring and a clear to the same bit in the same cycle, which tests the set-wins rule. They also write all-zero data, which shows that a written 0 has no effect. Random traffic then drives every port at once with random selects and multi-bit data. This covers many simultaneous senders to one receiver, a processor ringing itself, and an interrupt that must stay up while other bits of its register are cleared. It also catches any swap of the owner and bit axes, because every bit is compared against a model that uses the opposite index order.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
    typedef enum logic [1:0] {
        REG_RING = 2'd0,
        REG_PEND = 2'd1,
        REG_ACK  = 2'd2,
        REG_DONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mbox_status_bank.sv
`timescale 1ns/1ps
// Matrix of sticky status bits: row = owner, column = peer. Set beats clear.
module mbox_status_bank #(
    parameter int NP = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP*NP-1:0] set_i,
    input  logic [NP*NP-1:0] clr_i,
    output logic [NP*NP-1:0] stat_o,
    output logic [NP-1:0]    irq_o
);
    localparam int NB = NP * NP;

    typedef struct packed {
        logic [NB-1:0] stat;
        logic [NP-1:0] irq;
    } bank_s;

    bank_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr_i) | set_i;
        for (int o = 0; o < NP; o++) begin
            st_d.irq[o] = |st_d.stat[o*NP +: NP];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign irq_o  = st_q.irq;

    for (genvar b = 0; b < NB; b++) begin : g_bit_chk
        // R1, R4 and R8: a set always lands, even against a clear
        p_set_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> stat_o[b]);
        // R3 and R6: clear without a competing set empties the bit
        p_clear_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !stat_o[b]);
        // R7: nothing aimed at the bit means it holds
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[b] && !clr_i[b]) |=> $stable(stat_o[b]));
    end

    for (genvar o = 0; o < NP; o++) begin : g_irq_chk
        // R2 and R5: combined interrupt tracks its row
        p_irq_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[o] == (|stat_o[o*NP +: NP]));
    end
endmodule

// File: rtl/mbox_read_port.sv
`timescale 1ns/1ps
// Read mux for one processor's register window.
module mbox_read_port #(
    parameter int NP = 7
) (
    input  logic [1:0]    sel_i,
    input  logic [NP-1:0] pend_row_i,
    input  logic [NP-1:0] done_row_i,
    output logic [NP-1:0] rdata_o
);
    import mbox_pkg::*;

    always_comb begin
        case (reg_sel_e'(sel_i))
            REG_PEND: rdata_o = pend_row_i;
            REG_DONE: rdata_o = done_row_i;
            default:  rdata_o = '0;   // trigger registers read zero (R7)
        endcase
    end
endmodule

// File: rtl/mbox_doorbell.sv
`timescale 1ns/1ps
module mbox_doorbell #(
    parameter int NPROC = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPROC-1:0]       bus_we,
    input  logic [2*NPROC-1:0]     bus_sel,
    input  logic [NPROC*NPROC-1:0] bus_wdata,
    output logic [NPROC*NPROC-1:0] bus_rdata,
    output logic [NPROC-1:0]       irq_req,
    output logic [NPROC-1:0]       irq_ack
);
    import mbox_pkg::*;

    localparam int NP = NPROC;
    localparam int NB = NP * NP;

    logic [NP-1:0] wr_ring, wr_pend, wr_ack, wr_done;
    logic [NB-1:0] pend_set, pend_clr, done_set, done_clr;
    logic [NB-1:0] pend_stat, done_stat;

    for (genvar a = 0; a < NP; a++) begin : g_dec
        assign wr_ring[a] = bus_we[a] && (bus_sel[2*a +: 2] == REG_RING);
        assign wr_pend[a] = bus_we[a] && (bus_sel[2*a +: 2] == REG_PEND);
        assign wr_ack[a]  = bus_we[a] && (bus_sel[2*a +: 2] == REG_ACK);
        assign wr_done[a] = bus_we[a] && (bus_sel[2*a +: 2] == REG_DONE);
    end

    // Pending matrix: row = receiver r, column = sender s.
    // Done matrix: row = sender s, column = receiver r.
    for (genvar r = 0; r < NP; r++) begin : g_row
        for (genvar s = 0; s < NP; s++) begin : g_col
            assign pend_set[r*NP + s] = wr_ring[s] & bus_wdata[s*NP + r];
            assign pend_clr[r*NP + s] = wr_pend[r] & bus_wdata[r*NP + s];
            assign done_set[s*NP + r] = wr_ack[r]  & bus_wdata[r*NP + s];
            assign done_clr[s*NP + r] = wr_done[s] & bus_wdata[s*NP + r];
        end
    end

    mbox_status_bank #(.NP(NP)) u_pend_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pend_set),
        .clr_i  (pend_clr),
        .stat_o (pend_stat),
        .irq_o  (irq_req)
    );

    mbox_status_bank #(.NP(NP)) u_done_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (done_set),
        .clr_i  (done_clr),
        .stat_o (done_stat),
        .irq_o  (irq_ack)
    );

    for (genvar p = 0; p < NP; p++) begin : g_rd
        mbox_read_port #(.NP(NP)) u_rd (
            .sel_i      (bus_sel[2*p +: 2]),
            .pend_row_i (pend_stat[p*NP +: NP]),
            .done_row_i (done_stat[p*NP +: NP]),
            .rdata_o    (bus_rdata[p*NP +: NP])
        );
    end
endmodule

// File: tb/mbox_doorbell_bench.sv
`timescale 1ns/1ps
module mbox_doorbell_bench;
    localparam int NP = 7;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NP-1:0]       bus_we;
    logic [2*NP-1:0]     bus_sel;
    logic [NP*NP-1:0]    bus_wdata;
    logic [NP*NP-1:0]    bus_rdata;
    logic [NP-1:0]       irq_req, irq_ack;

    logic          we_v  [NP];
    logic [1:0]    sel_v [NP];
    logic [NP-1:0] wd_v  [NP];
    logic [NP-1:0] pend_m [NP];
    logic [NP-1:0] done_m [NP];

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            bus_we[p]            = we_v[p];
            bus_sel[2*p +: 2]    = sel_v[p];
            bus_wdata[p*NP +: NP] = wd_v[p];
        end
    end

    mbox_doorbell #(.NPROC(NP)) u_mbox_doorbell (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_ack(irq_ack)
    );

    task automatic chk(input string req, input string what, input logic [NP-1:0] got,
                       input logic [NP-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    function automatic logic [NP-1:0] exp_rd(input int p);
        case (sel_v[p])
            2'd1:    return pend_m[p];
            2'd3:    return done_m[p];
            default: return '0;
        endcase
    endfunction

    task automatic idle();
        for (int p = 0; p < NP; p++) begin
            we_v[p] = 1'b0; sel_v[p] = 2'd1; wd_v[p] = '0;
        end
    endtask

    // Compare outputs against the model, advance the model by the driven writes,
    // then cross one rising edge and return at the following falling edge.
    task automatic step();
        logic [NP-1:0] np_m [NP];
        logic [NP-1:0] nd_m [NP];
        #1;
        for (int p = 0; p < NP; p++) begin
            string tag;
            tag = (sel_v[p] == 2'd1) ? "R1" : (sel_v[p] == 2'd3) ? "R4" : "R7";
            chk(tag, $sformatf("rdata port %0d sel %0d", p, sel_v[p]),
                bus_rdata[p*NP +: NP], exp_rd(p));
        end
        for (int p = 0; p < NP; p++) begin
            chk("R2", $sformatf("irq_req %0d", p), NP'(irq_req[p]), NP'(|pend_m[p]));
            chk("R5", $sformatf("irq_ack %0d", p), NP'(irq_ack[p]), NP'(|done_m[p]));
        end
        for (int o = 0; o < NP; o++) begin
            np_m[o] = pend_m[o];
            nd_m[o] = done_m[o];
            if (we_v[o] && sel_v[o] == 2'd1) np_m[o] = np_m[o] & ~wd_v[o];
            if (we_v[o] && sel_v[o] == 2'd3) nd_m[o] = nd_m[o] & ~wd_v[o];
        end
        for (int a = 0; a < NP; a++) begin
            for (int b = 0; b < NP; b++) begin
                if (we_v[a] && sel_v[a] == 2'd0 && wd_v[a][b]) np_m[b][a] = 1'b1;
                if (we_v[a] && sel_v[a] == 2'd2 && wd_v[a][b]) nd_m[b][a] = 1'b1;
            end
        end
        for (int o = 0; o < NP; o++) begin
            pend_m[o] = np_m[o];
            done_m[o] = nd_m[o];
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [NP-1:0] peek(input int p, input logic [1:0] sel);
        return bus_rdata[p*NP +: NP];
    endfunction

    task automatic look(input int p, input logic [1:0] sel, output logic [NP-1:0] v);
        idle();
        sel_v[p] = sel;
        #1;
        v = peek(p, sel);
    endtask

    initial begin
        logic [NP-1:0] v;
        void'($urandom(32'd4242));
        idle();
        for (int p = 0; p < NP; p++) begin
            pend_m[p] = '0; done_m[p] = '0;
        end
        repeat (3) @(negedge clk);
        // R9: reset state visible while reset is held
        #1;
        chk("R9", "irq_req in reset", irq_req, '0);
        chk("R9", "irq_ack in reset", irq_ack, '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            look(p, 2'd1, v); chk("R9", $sformatf("pending %0d after reset", p), v, '0);
            look(p, 2'd3, v); chk("R9", $sformatf("done %0d after reset", p), v, '0);
        end

        // R10: exchange between index 0 and index 6
        idle(); we_v[0] = 1; sel_v[0] = 2'd0; wd_v[0] = NP'(1) << 6; step();
        look(6, 2'd1, v); chk("R10", "pending of 6 after ring", v, NP'(1));
        chk("R10", "irq_req of 6", NP'(irq_req[6]), NP'(1));
        look(0, 2'd0, v); chk("R7", "ring trigger reads zero", v, '0);
        idle(); we_v[6] = 1; sel_v[6] = 2'd1; wd_v[6] = NP'(1); step();
        look(6, 2'd1, v); chk("R3", "pending of 6 cleared", v, '0);
        chk("R3", "irq_req of 6 dropped", NP'(irq_req[6]), '0);
        idle(); we_v[6] = 1; sel_v[6] = 2'd2; wd_v[6] = NP'(1); step();
        look(0, 2'd3, v); chk("R4", "done of 0 after ack", v, NP'(1) << 6);
        chk("R5", "irq_ack of 0", NP'(irq_ack[0]), NP'(1));
        look(6, 2'd2, v); chk("R7", "ack trigger reads zero", v, '0);
        idle(); we_v[0] = 1; sel_v[0] = 2'd3; wd_v[0] = NP'(1) << 6; step();
        look(0, 2'd3, v); chk("R6", "done of 0 cleared", v, '0);
        chk("R10", "irq_ack of 0 dropped", NP'(irq_ack[0]), '0);

        // R8: ring and clear on the same bit in one cycle
        idle(); we_v[2] = 1; sel_v[2] = 2'd0; wd_v[2] = NP'(1) << 3; step();
        idle(); we_v[2] = 1; sel_v[2] = 2'd0; wd_v[2] = NP'(1) << 3;
        we_v[3] = 1; sel_v[3] = 2'd1; wd_v[3] = NP'(1) << 2; step();
        look(3, 2'd1, v); chk("R8", "set wins over clear", v, NP'(1) << 2);
        // R7: zero-data writes to every register leave state alone
        for (int s = 0; s < 4; s++) begin
            idle();
            for (int p = 0; p < NP; p++) begin
                we_v[p] = 1; sel_v[p] = 2'(s); wd_v[p] = '0;
            end
            step();
        end
        look(3, 2'd1, v); chk("R7", "zero writes keep pending", v, NP'(1) << 2);

        // Random traffic on all ports
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < NP; p++) begin
                we_v[p]  = ($urandom % 2) == 0;
                sel_v[p] = 2'($urandom % 4);
                wd_v[p]  = NP'($urandom) & NP'($urandom);
            end
            step();
        end
        idle();
        step();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule